// File: doc/BRIEF.md
# Trace Capture Arm/Stop Controller

This block decides when a trace buffer starts and stops recording. Software sets three 3-bit selector codes and an enable. The start selector names the event that moves the controller from armed to triggered. The stop selector names the event that ends recording. The interface selector names the internal interface that feeds capture. Event inputs are:

- a watchpoint hit
- a trace-comparator hit
- a performance-monitor overflow
- an external trigger pin
- a running context ID, compared against a programmed one

While triggered, the block drives a write enable and a write pointer for a trace RAM. The RAM itself is outside the block, and so is the capture datapath.

The controller runs through four states in order: idle, armed, triggered, stopped. A stop event counts only after a trigger has happened since arming. Each selector is evaluated only in its own state, so one event cannot both start and end a capture on the same edge. The interface code passes straight through to the datapath. The two reserved interface codes block all writes.

Top module: `trc_arm_ctrl`

## Requirements
- R1: After reset, armed_o, triggered_o, stopped_o, trig_seen_o, full_o and wr_en_o are low and wr_ptr_o is 0.
- R2: With enable_i high, the idle state moves to armed on the next edge. With enable_i low, any state returns to idle on the next edge, and the pointer, full_o and trig_seen_o are cleared.
- R3: Start code 0 is an event that is always present, so triggered_o rises one edge after armed_o.
- R4: Start codes 1, 2 and 3 select wpt_hit_i, tbc_hit_i and pmon_ovf_i. Events that are not selected leave the armed state unchanged.
- R5: Codes 4 and 5 select a rising and a falling edge of ext_trig_i, taken against its value at the previous edge. A level held steady is not an event.
- R6: Codes 6 and 7 select ctx_id_i equal to ctx_prog_i, and ctx_id_i not equal to ctx_prog_i.
- R7: The start selector is evaluated only in the armed state and the stop selector only in the triggered state. An event that triggers the capture does not also stop it.
- R8: wr_en_o is high only in the triggered state, with cap_valid_i high, enable_i high and a non-reserved interface code. Each write advances wr_ptr_o by one, and the pointer wraps from DEPTH-1 to 0.
- R9: A write to entry DEPTH-1 sets full_o. full_o stays set until the controller returns to idle.
- R10: With stop code 0, the write to entry DEPTH-1 moves the controller to stopped on that same edge. No further writes follow.
- R11: Stop codes 1 to 7 use the same event mapping as the start codes and move triggered to stopped. Stopped holds, with no writes, until enable_i falls.
- R12: if_sel_o equals if_sel_i. Interface codes 3 and 7 are reserved and produce no writes.
- R13: trig_seen_o rises when the controller enters triggered and stays high through stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Software enable |
| start_sel_i | input | 3 | Start event code |
| stop_sel_i | input | 3 | Stop event code |
| if_sel_i | input | 3 | Interface select code |
| wpt_hit_i | input | 1 | Watchpoint hit |
| tbc_hit_i | input | 1 | Trace comparator hit |
| pmon_ovf_i | input | 1 | Performance monitor overflow |
| ext_trig_i | input | 1 | External trigger pin |
| ctx_id_i | input | CTX_W | Current context ID |
| ctx_prog_i | input | CTX_W | Programmed context ID |
| cap_valid_i | input | 1 | Capture data valid this cycle |
| if_sel_o | output | 3 | Interface select to datapath |
| armed_o | output | 1 | Armed state |
| triggered_o | output | 1 | Triggered state |
| stopped_o | output | 1 | Stopped state |
| trig_seen_o | output | 1 | Trigger seen since arming |
| wr_en_o | output | 1 | Trace RAM write enable |
| wr_ptr_o | output | PTR_W | Trace RAM write pointer |
| full_o | output | 1 | Last entry has been written |

## Verification
The bench builds the block with DEPTH set to 8 and CTX_W set to 8. With a depth of 8, a wrap of the pointer, the setting of the full flag and a stop on full are each reached within a handful of capture cycles. The 8-bit context IDs are wide enough to show both matching and differing values for the equality and inequality codes.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_TRIG    = 2'd2,
    ST_STOPPED = 2'd3
  } trc_state_e;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_WPT  = 3'd1,
    EV_TBC  = 3'd2,
    EV_PMON = 3'd3,
    EV_RISE = 3'd4,
    EV_FALL = 3'd5,
    EV_CEQ  = 3'd6,
    EV_CNE  = 3'd7
  } trc_evt_e;
endpackage

// File: rtl/trc_edge_det.sv
module trc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign rise_o = pin_i & ~pin_q;
  assign fall_o = ~pin_i & pin_q;
endmodule

// File: rtl/trc_evt_sel.sv
module trc_evt_sel
  import trc_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       zero_evt_i,
  input  logic       wpt_i,
  input  logic       tbc_i,
  input  logic       pmon_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       ctx_eq_i,
  output logic       evt_o
);
  always_comb begin
    unique case (trc_evt_e'(sel_i))
      EV_NONE: evt_o = zero_evt_i;
      EV_WPT:  evt_o = wpt_i;
      EV_TBC:  evt_o = tbc_i;
      EV_PMON: evt_o = pmon_i;
      EV_RISE: evt_o = rise_i;
      EV_FALL: evt_o = fall_i;
      EV_CEQ:  evt_o = ctx_eq_i;
      EV_CNE:  evt_o = ~ctx_eq_i;
      default: evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trc_wr_ptr.sv
module trc_wr_ptr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             last_wr_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic             full_q;

  assign last_wr_o = wr_i && (ptr_q == LAST);

  // power-of-two depth wraps naturally; otherwise compare
  generate
    if (DEPTH == (1 << PTR_W)) begin : g_pow2
      assign ptr_inc = ptr_q + 1'b1;
    end else begin : g_npow2
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (clear_i) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_i) begin
      ptr_q <= ptr_inc;
      if (last_wr_o) full_q <= 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = full_q;
endmodule

// File: rtl/trc_arm_ctrl.sv
module trc_arm_ctrl
  import trc_pkg::*;
#(
  parameter int unsigned CTX_W        = 8,
  parameter int unsigned DEPTH        = 16,
  parameter logic [7:0]  IF_RSVD_MASK = 8'b1000_1000,
  localparam int unsigned PTR_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [2:0]       start_sel_i,
  input  logic [2:0]       stop_sel_i,
  input  logic [2:0]       if_sel_i,
  input  logic             wpt_hit_i,
  input  logic             tbc_hit_i,
  input  logic             pmon_ovf_i,
  input  logic             ext_trig_i,
  input  logic [CTX_W-1:0] ctx_id_i,
  input  logic [CTX_W-1:0] ctx_prog_i,
  input  logic             cap_valid_i,
  output logic [2:0]       if_sel_o,
  output logic             armed_o,
  output logic             triggered_o,
  output logic             stopped_o,
  output logic             trig_seen_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             full_o
);
  trc_state_e state_q, state_d;
  logic trig_seen_q;
  logic rise, fall, ctx_eq;
  logic start_evt, stop_evt, last_wr, if_rsvd, ptr_clear;

  trc_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_trig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign ctx_eq = (ctx_id_i == ctx_prog_i);

  // start code 0: always present; stop code 0: last entry written
  trc_evt_sel u_start_sel (
    .sel_i      (start_sel_i),
    .zero_evt_i (1'b1),
    .wpt_i      (wpt_hit_i),
    .tbc_i      (tbc_hit_i),
    .pmon_i     (pmon_ovf_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .ctx_eq_i   (ctx_eq),
    .evt_o      (start_evt)
  );

  trc_evt_sel u_stop_sel (
    .sel_i      (stop_sel_i),
    .zero_evt_i (last_wr),
    .wpt_i      (wpt_hit_i),
    .tbc_i      (tbc_hit_i),
    .pmon_i     (pmon_ovf_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .ctx_eq_i   (ctx_eq),
    .evt_o      (stop_evt)
  );

  assign if_rsvd   = IF_RSVD_MASK[if_sel_i];
  assign wr_en_o   = enable_i && (state_q == ST_TRIG) && cap_valid_i && !if_rsvd;
  assign ptr_clear = !enable_i || (state_q == ST_IDLE);

  trc_wr_ptr #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (ptr_clear),
    .wr_i      (wr_en_o),
    .ptr_o     (wr_ptr_o),
    .last_wr_o (last_wr),
    .full_o    (full_o)
  );

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    state_d = ST_ARMED;
        ST_ARMED:   if (start_evt) state_d = ST_TRIG;
        ST_TRIG:    if (stop_evt && trig_seen_q) state_d = ST_STOPPED;
        ST_STOPPED: state_d = ST_STOPPED;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      trig_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!enable_i)                              trig_seen_q <= 1'b0;
      else if (state_q == ST_ARMED && start_evt)  trig_seen_q <= 1'b1;
    end
  end

  assign if_sel_o    = if_sel_i;
  assign armed_o     = (state_q == ST_ARMED);
  assign triggered_o = (state_q == ST_TRIG);
  assign stopped_o   = (state_q == ST_STOPPED);
  assign trig_seen_o = trig_seen_q;
endmodule

// File: rtl/trc_arm_ctrl_chk.sv
module trc_arm_ctrl_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [2:0]       if_sel_i,
  input logic             armed_o,
  input logic             triggered_o,
  input logic             stopped_o,
  input logic             trig_seen_o,
  input logic             wr_en_o,
  input logic [PTR_W-1:0] wr_ptr_o,
  input logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  AST_ONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({armed_o, triggered_o, stopped_o})); // R7
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !armed_o && !triggered_o && !stopped_o && !full_o && !trig_seen_o); // R2
  AST_WR_ONLY_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> triggered_o); // R8
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_ptr_o != LAST |=> wr_ptr_o == PTR_W'($past(wr_ptr_o) + 1'b1)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !wr_en_o |=> $stable(wr_ptr_o)); // R8
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && full_o |=> full_o); // R9
  AST_FULL_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_ptr_o == LAST |=> full_o && wr_ptr_o == '0); // R9
  AST_STOP_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> $past(triggered_o)); // R11
  AST_RSVD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_sel_i == 3'd3 || if_sel_i == 3'd7) |-> !wr_en_o); // R12
  AST_SEEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o || stopped_o) |-> trig_seen_o); // R13
endmodule

bind trc_arm_ctrl trc_arm_ctrl_chk #(
  .DEPTH (DEPTH),
  .PTR_W (PTR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .if_sel_i    (if_sel_i),
  .armed_o     (armed_o),
  .triggered_o (triggered_o),
  .stopped_o   (stopped_o),
  .trig_seen_o (trig_seen_o),
  .wr_en_o     (wr_en_o),
  .wr_ptr_o    (wr_ptr_o),
  .full_o      (full_o)
);

// File: tb/trc_arm_ctrl_bench.sv
module trc_arm_ctrl_bench;
  localparam int unsigned CTX_W = 8;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned PTR_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] start_sel = '0, stop_sel = '0, if_sel = '0;
  logic wpt = 1'b0, tbc = 1'b0, pmon = 1'b0, ext = 1'b0, cap = 1'b0;
  logic [CTX_W-1:0] ctx_id = '0, ctx_prog = '0;
  logic [2:0] if_sel_o;
  logic armed, trig, stopped, seen, wr_en, full;
  logic [PTR_W-1:0] ptr;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trc_arm_ctrl #(.CTX_W(CTX_W), .DEPTH(DEPTH)) u_trc_arm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .start_sel_i(start_sel), .stop_sel_i(stop_sel), .if_sel_i(if_sel),
    .wpt_hit_i(wpt), .tbc_hit_i(tbc), .pmon_ovf_i(pmon), .ext_trig_i(ext),
    .ctx_id_i(ctx_id), .ctx_prog_i(ctx_prog), .cap_valid_i(cap),
    .if_sel_o(if_sel_o), .armed_o(armed), .triggered_o(trig), .stopped_o(stopped),
    .trig_seen_o(seen), .wr_en_o(wr_en), .wr_ptr_o(ptr), .full_o(full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic int st();
    return {29'd0, stopped, trig, armed};
  endfunction

  task automatic go_idle();
    enable = 1'b0; cap = 1'b0; wpt = 1'b0; tbc = 1'b0; pmon = 1'b0;
    step(2);
  endtask

  task automatic pulse(input int code);
    wpt = (code == 1); tbc = (code == 2); pmon = (code == 3);
    step();
    wpt = 1'b0; tbc = 1'b0; pmon = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", st(), 0);
    chk("R1 seen/full/wr", {seen, full, wr_en}, 0);
    chk("R1 ptr", ptr, 0);
  endtask

  task automatic t_basic();
    start_sel = 3'd0; stop_sel = 3'd1; if_sel = 3'd0;
    enable = 1'b1;
    step();
    chk("R2 armed", st(), 1);
    step();
    chk("R3 triggered", st(), 2);
    chk("R13 seen", seen, 1);
    cap = 1'b1;
    step(3);
    cap = 1'b0;
    chk("R8 ptr after 3", ptr, 3);
    pulse(1);
    chk("R11 stopped on wpt", st(), 4);
    chk("R13 seen in stopped", seen, 1);
    cap = 1'b1;
    step(2);
    chk("R11 no write stopped", ptr, 3);
    chk("R11 stopped holds", st(), 4);
    cap = 1'b0;
    enable = 1'b0;
    step();
    chk("R2 idle", st(), 0);
    chk("R2 ptr cleared", ptr, 0);
    chk("R2 seen cleared", seen, 0);
  endtask

  task automatic t_start_sel();
    for (int c = 1; c <= 3; c++) begin
      start_sel = 3'(c); stop_sel = 3'(c);
      enable = 1'b1;
      step();
      pulse((c % 3) + 1);
      pulse(((c + 1) % 3) + 1);
      chk("R4 unselected ignored", st(), 1);
      pulse(c);
      chk("R4 selected triggers", st(), 2);
      step();
      chk("R7 same event no stop", st(), 2);
      go_idle();
    end
  endtask

  task automatic t_edges();
    start_sel = 3'd4; stop_sel = 3'd1;
    ext = 1'b1;
    step();
    enable = 1'b1;
    step(3);
    chk("R5 steady high no rise", st(), 1);
    ext = 1'b0;
    step();
    chk("R5 fall not rise", st(), 1);
    ext = 1'b1;
    step();
    chk("R5 rise triggers", st(), 2);
    go_idle();
    start_sel = 3'd5;
    enable = 1'b1;
    step(3);
    chk("R5 steady high no fall", st(), 1);
    ext = 1'b0;
    step();
    chk("R5 fall triggers", st(), 2);
    go_idle();
    start_sel = 3'd0; stop_sel = 3'd4;
    enable = 1'b1;
    step(2);
    ext = 1'b1;
    step();
    chk("R11 stop on rise", st(), 4);
    ext = 1'b0;
    go_idle();
  endtask

  task automatic t_ctx();
    start_sel = 3'd6; stop_sel = 3'd1;
    ctx_prog = 8'h5A; ctx_id = 8'h11;
    enable = 1'b1;
    step(3);
    chk("R6 ne holds for eq code", st(), 1);
    ctx_id = 8'h5A;
    step();
    chk("R6 eq triggers", st(), 2);
    go_idle();
    start_sel = 3'd7;
    enable = 1'b1;
    step(3);
    chk("R6 eq holds for ne code", st(), 1);
    ctx_id = 8'hA5;
    step();
    chk("R6 ne triggers", st(), 2);
    go_idle();
  endtask

  task automatic t_full();
    start_sel = 3'd0; stop_sel = 3'd0; if_sel = 3'd1;
    enable = 1'b1;
    step(2);
    cap = 1'b1;
    step(DEPTH - 1);
    chk("R9 ptr last", ptr, DEPTH - 1);
    chk("R9 not yet full", full, 0);
    chk("R10 still triggered", st(), 2);
    step();
    chk("R10 stopped on last", st(), 4);
    chk("R9 full set", full, 1);
    chk("R8 wrap to 0", ptr, 0);
    step(2);
    chk("R10 no writes after", ptr, 0);
    go_idle();
    chk("R2 full cleared", full, 0);
    stop_sel = 3'd2;
    enable = 1'b1;
    step(2);
    cap = 1'b1;
    step(DEPTH + 1);
    cap = 1'b0;
    chk("R9 wraps on", ptr, 1);
    chk("R9 full sticky", full, 1);
    chk("R11 no stop without event", st(), 2);
    go_idle();
  endtask

  task automatic t_rsvd();
    start_sel = 3'd0; stop_sel = 3'd1;
    for (int k = 0; k < 2; k++) begin
      if_sel = (k == 0) ? 3'd3 : 3'd7;
      enable = 1'b1;
      step(2);
      chk("R12 pass-through", if_sel_o, int'(if_sel));
      cap = 1'b1;
      step(3);
      chk("R12 no write reserved", ptr, 0);
      go_idle();
    end
    if_sel = 3'd6;
    enable = 1'b1;
    step(2);
    cap = 1'b1;
    step(2);
    chk("R12 code 6 writes", ptr, 2);
    chk("R12 pass-through 6", if_sel_o, 6);
    go_idle();
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_start_sel();
    t_edges();
    t_ctx();
    t_full();
    t_rsvd();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule